// File: doc/BRIEF.md
# Disk DMA transfer sequencer

This block follows a single disk-side DMA transfer between a drive (either a packet-command optical drive or a hard disk) and a descriptor-driven DMA channel. A start pulse arms the transfer. It loads a remaining byte count and the starting block address, then sets an active flag and kicks the channel. The channel then hands over chunks one at a time. Each chunk carries a memory address and a length. For each chunk the sequencer decides whether to park the channel, end the burst, end the whole drive transfer, or send one medium request with a computed byte offset. The medium request port uses a valid/ready handshake, followed later by a response.

Each chunk ends with one outcome pulse back to the channel. A hard-disk completion also updates the drive status and raises a drive interrupt pulse. An optical completion gives a command-done pulse. Packet transfers whose block address is all ones carry no block data. They are served by one direct memory-copy request instead of a medium access.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `active` is 0, `chunk_ready` is 1, `req_valid` and every pulse output are 0, and `drv_status` is 0x00.
- R2: A start pulse in the idle state produces a one-cycle `kick` in the next cycle, with `active` high. It also sets the running index to 0, clears `drv_status` to 0x00, and loads the remaining count. That count is `pkt_size` for an optical drive (`is_optical`=1) and `sect_cnt`*512 for a hard disk.
- R3: A chunk accepted while `active` is 0 (and without `chunk_err`) gives a `chan_park` pulse two cycles after acceptance. It gives no `dma_end` and no request.
- R4: A chunk evaluated with remaining count at or below zero ends the drive transfer. `dma_end` pulses and `active` drops. For a hard disk, `drv_status` becomes 0x50 and `drv_irq` pulses with `dma_end`. For an optical drive, `cmd_ok` pulses with `dma_end` and `drv_status` stays 0x00.
- R5: A zero-length chunk with a positive remaining count pulses only `dma_end`. `active` stays 1 and no request is made.
- R6: The request byte offset is the block address shifted left by 11 for an optical drive, or left by 9 for a hard disk, plus the running index, in 64 bits.
- R7: A block chunk of length L issues one request with `req_addr` equal to the chunk address and `req_len` equal to L. It then lowers the remaining count by L and raises the running index by L.
- R8: For an optical transfer whose block address is all ones, a chunk of length L issues one request of kind 3 (direct copy) with length min(remaining, L). After its response there is a `cmd_ok` and `dma_end` pulse and `active` drops.
- R9: For a hard disk, `cmd` 0, 1 and 2 give request kinds 0 (read), 1 (write) and 2 (trim). `cmd` 3 gives `dma_err` with `dma_end`, clears `active` and makes no request. Optical block transfers always use kind 0, whatever `cmd` is.
- R10: A chunk presented with `chunk_err`, or a response returned with `rsp_err`, pulses `dma_err` together with `dma_end` and clears `active`.
- R11: While `req_valid` is high and `req_ready` is low, the request and its fields hold steady.
- R12: After an error-free block response, the sequencer re-evaluates with a zero chunk length. If the remaining count is now at or below zero it ends the transfer (R4); otherwise it pulses only `dma_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new transfer (sampled when idle) |
| is_optical | input | 1 | 1 = packet optical drive, 0 = hard disk |
| pkt_size | input | CNT_W | Packet transfer byte count |
| sect_cnt | input | SECT_W | Hard-disk sector count |
| blk_addr | input | LBA_W | Starting block address |
| cmd | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| kick | output | 1 | One-cycle channel kick after start |
| active | output | 1 | Transfer armed |
| chunk_valid | input | 1 | Channel offers a chunk |
| chunk_ready | output | 1 | Sequencer accepts a chunk |
| chunk_addr | input | ADDR_W | Chunk memory address |
| chunk_len | input | LEN_W | Chunk byte length |
| chunk_err | input | 1 | Chunk carries an error |
| req_valid | output | 1 | Medium request valid |
| req_ready | input | 1 | Medium request accepted |
| req_kind | output | 2 | 0 read, 1 write, 2 trim, 3 direct copy |
| req_addr | output | ADDR_W | Memory address of request |
| req_len | output | LEN_W | Byte length of request |
| req_offset | output | OFF_W | Byte offset into the medium |
| rsp_valid | input | 1 | Request finished |
| rsp_err | input | 1 | Request finished with error |
| dma_end | output | 1 | One-cycle end-of-chunk pulse to the channel |
| chan_park | output | 1 | One-cycle release of the channel, not processing |
| dma_err | output | 1 | One-cycle DMA error pulse |
| cmd_ok | output | 1 | One-cycle optical command completion |
| drv_irq | output | 1 | One-cycle hard-disk drive interrupt |
| drv_status | output | 8 | Drive status byte |

## Verification
The hardest case to reach from the ports is a chunk evaluated while the remaining count is already negative or zero, without the sequencer having ended the transfer itself on an earlier response. The bench gets there in two ways. It starts a hard-disk transfer with a sector count of zero, and it sends optical chunks larger than the packet size, so the count crosses below zero inside one step. The park path needs a chunk presented with no transfer armed. The bench does this both straight after reset and straight after each completion. Offsets are swept across block addresses up to the top of the 32-bit range, so a missing widening to 64 bits shows up in the upper word.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_TRIM  = 2'd2,
    KIND_COPY  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    D_ERR       = 3'd0,
    D_PARK      = 3'd1,
    D_COPYDONE  = 3'd2,
    D_XFER_END  = 3'd3,
    D_BURST_END = 3'd4,
    D_COPY      = 3'd5,
    D_BADCMD    = 3'd6,
    D_BLOCK     = 3'd7
  } decision_e;

  localparam int OPT_SHIFT     = 11;
  localparam int HD_SHIFT      = 9;
  localparam int SECTOR_SHIFT  = 9;
  localparam logic [7:0] STAT_DONE = 8'h50;
  localparam logic [7:0] STAT_ARMED = 8'h00;
endpackage

// File: rtl/dxs_counter.sv
module dxs_counter #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        load_val,
  input  logic                    step,
  input  logic [LEN_W-1:0]        step_len,
  output logic signed [CNT_W-1:0] remain,
  output logic [CNT_W-1:0]        idx
);
  localparam int PAD_W = CNT_W - LEN_W;

  function automatic logic [CNT_W-1:0] widen(input logic [LEN_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      idx    <= '0;
    end else if (load) begin
      remain <= $signed(load_val);
      idx    <= '0;
    end else if (step) begin
      remain <= remain - $signed(widen(step_len));
      idx    <= idx + widen(step_len);
    end
  end

  // R7
  step_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> idx == $past(idx) + widen($past(step_len)));

  // R7
  step_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> ($unsigned(remain) + idx) == ($unsigned($past(remain)) + $past(idx)));

  // R2
  load_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> idx == '0);
endmodule

// File: rtl/dxs_offset.sv
module dxs_offset #(
  parameter int LBA_W = 32,
  parameter int CNT_W = 32,
  parameter int OFF_W = 64
) (
  input  logic [LBA_W-1:0] blk,
  input  logic [CNT_W-1:0] idx,
  input  logic             optical,
  output logic [OFF_W-1:0] offset
);
  import dxs_pkg::*;

  function automatic logic [OFF_W-1:0] medium_offset(
    input logic [LBA_W-1:0] b, input logic [CNT_W-1:0] i, input logic opt);
    logic [OFF_W-1:0] base;
    base = {{(OFF_W-LBA_W){1'b0}}, b};
    if (opt) base = base << OPT_SHIFT;
    else     base = base << HD_SHIFT;
    return base + {{(OFF_W-CNT_W){1'b0}}, i};
  endfunction

  assign offset = medium_offset(blk, idx, optical);
endmodule

// File: rtl/dxs_reqport.sv
module dxs_reqport #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [1:0]        kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [OFF_W-1:0]  req_offset,
  output logic              hs
);
  assign hs = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_kind   <= '0;
      req_addr   <= '0;
      req_len    <= '0;
      req_offset <= '0;
    end else if (issue) begin
      req_valid  <= 1'b1;
      req_kind   <= kind_in;
      req_addr   <= addr_in;
      req_len    <= len_in;
      req_offset <= off_in;
    end else if (hs) begin
      req_valid  <= 1'b0;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_offset) &&
                                $stable(req_len) && $stable(req_addr) && $stable(req_kind));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int LBA_W  = 32,
  parameter int OFF_W  = 64,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_optical,
  input  logic [CNT_W-1:0]  pkt_size,
  input  logic [SECT_W-1:0] sect_cnt,
  input  logic [LBA_W-1:0]  blk_addr,
  input  logic [1:0]        cmd,
  output logic              kick,
  output logic              active,
  input  logic              chunk_valid,
  output logic              chunk_ready,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic              chunk_err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [OFF_W-1:0]  req_offset,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              dma_end,
  output logic              chan_park,
  output logic              dma_err,
  output logic              cmd_ok,
  output logic              drv_irq,
  output logic [7:0]        drv_status
);
  import dxs_pkg::*;

  localparam int PAD_W = CNT_W - LEN_W;

  seq_state_e       state;
  decision_e        dec;
  logic             opt_q, copy_pend, c_err;
  logic [LBA_W-1:0] blk_q;
  logic [1:0]       cmd_q;
  logic [ADDR_W-1:0] c_addr;
  logic [LEN_W-1:0] c_len;
  logic signed [CNT_W-1:0] remain;
  logic [CNT_W-1:0] idx;
  logic [OFF_W-1:0] offset;
  logic             hs;

  // named internal events
  logic ev_load, ev_step, ev_issue, chunk_hs, remain_le0, blk_nonblock;
  logic [1:0]       issue_kind;
  logic [LEN_W-1:0] issue_len;

  function automatic logic [CNT_W-1:0] start_count(
    input logic opt, input logic [CNT_W-1:0] pkt, input logic [SECT_W-1:0] sc);
    logic [CNT_W-1:0] hd;
    hd = {{(CNT_W-SECT_W){1'b0}}, sc} << SECTOR_SHIFT;
    return opt ? pkt : hd;
  endfunction

  function automatic logic not_positive(input logic signed [CNT_W-1:0] r);
    return r[CNT_W-1] | ~|r;
  endfunction

  function automatic logic [LEN_W-1:0] copy_size(
    input logic signed [CNT_W-1:0] r, input logic [LEN_W-1:0] l);
    logic [CNT_W-1:0] lw;
    lw = {{PAD_W{1'b0}}, l};
    return ($unsigned(r) < lw) ? r[LEN_W-1:0] : l;
  endfunction

  assign chunk_ready  = (state == ST_IDLE) && !start;
  assign chunk_hs     = chunk_ready && chunk_valid;
  assign ev_load      = (state == ST_IDLE) && start;
  assign remain_le0   = not_positive(remain);
  assign blk_nonblock = opt_q && (&blk_q);

  always_comb begin
    if (c_err)                       dec = D_ERR;
    else if (!active)                dec = D_PARK;
    else if (copy_pend)              dec = D_COPYDONE;
    else if (remain_le0)             dec = D_XFER_END;
    else if (c_len == '0)            dec = D_BURST_END;
    else if (blk_nonblock)           dec = D_COPY;
    else if (!opt_q && cmd_q == 2'd3) dec = D_BADCMD;
    else                             dec = D_BLOCK;
  end

  assign ev_step    = (state == ST_EVAL) && (dec == D_BLOCK);
  assign ev_issue   = (state == ST_EVAL) && (dec == D_BLOCK || dec == D_COPY);
  assign issue_kind = (dec == D_COPY) ? KIND_COPY : (opt_q ? KIND_READ : cmd_q);
  assign issue_len  = (dec == D_COPY) ? copy_size(remain, c_len) : c_len;

  dxs_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(ev_load),
    .load_val(start_count(is_optical, pkt_size, sect_cnt)),
    .step(ev_step), .step_len(c_len), .remain(remain), .idx(idx));

  dxs_offset #(.LBA_W(LBA_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_off (
    .blk(blk_q), .idx(idx), .optical(opt_q), .offset(offset));

  dxs_reqport #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_req (
    .clk(clk), .rst_n(rst_n), .issue(ev_issue), .kind_in(issue_kind),
    .addr_in(c_addr), .len_in(issue_len), .off_in(offset),
    .req_ready(req_ready), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_offset(req_offset), .hs(hs));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      active     <= 1'b0;
      opt_q      <= 1'b0;
      blk_q      <= '0;
      cmd_q      <= '0;
      c_addr     <= '0;
      c_len      <= '0;
      c_err      <= 1'b0;
      copy_pend  <= 1'b0;
      kick       <= 1'b0;
      dma_end    <= 1'b0;
      chan_park  <= 1'b0;
      dma_err    <= 1'b0;
      cmd_ok     <= 1'b0;
      drv_irq    <= 1'b0;
      drv_status <= STAT_ARMED;
    end else begin
      kick      <= 1'b0;
      dma_end   <= 1'b0;
      chan_park <= 1'b0;
      dma_err   <= 1'b0;
      cmd_ok    <= 1'b0;
      drv_irq   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ev_load) begin
            opt_q      <= is_optical;
            blk_q      <= blk_addr;
            cmd_q      <= cmd;
            active     <= 1'b1;
            kick       <= 1'b1;
            copy_pend  <= 1'b0;
            drv_status <= STAT_ARMED;
          end else if (chunk_hs) begin
            c_addr <= chunk_addr;
            c_len  <= chunk_len;
            c_err  <= chunk_err;
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          state <= ST_IDLE;
          c_err <= 1'b0;
          unique case (dec)
            D_ERR, D_BADCMD: begin
              dma_err   <= 1'b1;
              dma_end   <= 1'b1;
              active    <= 1'b0;
              copy_pend <= 1'b0;
            end
            D_PARK: chan_park <= 1'b1;
            D_COPYDONE: begin
              cmd_ok    <= 1'b1;
              dma_end   <= 1'b1;
              active    <= 1'b0;
              copy_pend <= 1'b0;
            end
            D_XFER_END: begin
              if (opt_q) cmd_ok <= 1'b1;
              else begin
                drv_irq    <= 1'b1;
                drv_status <= STAT_DONE;
              end
              dma_end <= 1'b1;
              active  <= 1'b0;
            end
            D_BURST_END: dma_end <= 1'b1;
            D_COPY: begin
              copy_pend <= 1'b1;
              c_len     <= '0;
              state     <= ST_ISSUE;
            end
            D_BLOCK: begin
              c_len <= '0;
              state <= ST_ISSUE;
            end
            default: ;
          endcase
        end
        ST_ISSUE: if (hs) state <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            c_err <= rsp_err;
            state <= ST_EVAL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  park_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_park |-> !dma_end && !active);

  // R3
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_hs && !active && !chunk_err |-> ##2 chan_park);

  // R4
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_irq |-> dma_end && !active && drv_status == STAT_DONE);

  // R2
  kick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> active && !dma_end);

  // R10
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err |-> dma_end && !active && !cmd_ok);

  // R9
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_kind == KIND_COPY |-> opt_q);
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, is_optical = 0;
  logic [31:0] pkt_size = 0;
  logic [7:0]  sect_cnt = 0;
  logic [31:0] blk_addr = 0;
  logic [1:0]  cmd = 0;
  logic kick, active, chunk_ready;
  logic chunk_valid = 0, chunk_err = 0;
  logic [31:0] chunk_addr = 0;
  logic [15:0] chunk_len = 0;
  logic req_valid, req_ready = 0;
  logic [1:0] req_kind;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic [63:0] req_offset;
  logic rsp_valid = 0, rsp_err = 0;
  logic dma_end, chan_park, dma_err, cmd_ok, drv_irq;
  logic [7:0] drv_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_seq u_dma_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_optical(is_optical),
    .pkt_size(pkt_size), .sect_cnt(sect_cnt), .blk_addr(blk_addr), .cmd(cmd),
    .kick(kick), .active(active), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len), .chunk_err(chunk_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .dma_end(dma_end),
    .chan_park(chan_park), .dma_err(dma_err), .cmd_ok(cmd_ok),
    .drv_irq(drv_irq), .drv_status(drv_status));

  int checks = 0, failures = 0;
  bit finished = 0;

  // observations from the last chunk
  logic o_req, o_end, o_park, o_err, o_ok, o_irq, o_act;
  logic [1:0] o_kind;
  logic [31:0] o_addr;
  logic [15:0] o_len;
  logic [63:0] o_off;
  logic [7:0] o_stat;

  // bench model
  int m_remain;
  longint unsigned m_idx;
  bit m_opt, m_active;
  logic [31:0] m_blk;
  logic [1:0] m_cmd;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit opt, input logic [31:0] pkt, input logic [7:0] sc,
                          input logic [31:0] blk, input logic [1:0] c);
    @(negedge clk);
    start = 1; is_optical = opt; pkt_size = pkt; sect_cnt = sc; blk_addr = blk; cmd = c;
    @(negedge clk);
    start = 0;
    chk(kick === 1'b1 && active === 1'b1, "R2 kick/active after start", {kick, active}, 2'b11);
    @(negedge clk);
    chk(kick === 1'b0, "R2 kick is one cycle", kick, 0);
    m_opt = opt; m_blk = blk; m_cmd = c; m_idx = 0; m_active = 1;
    m_remain = opt ? int'(pkt) : int'(sc) * 512;
  endtask

  task automatic drive_chunk(input logic [31:0] a, input logic [15:0] l, input bit cerr, input bit rerr);
    bit fin = 0;
    o_req = 0; o_end = 0; o_park = 0; o_err = 0; o_ok = 0; o_irq = 0;
    @(negedge clk);
    chunk_valid = 1; chunk_addr = a; chunk_len = l; chunk_err = cerr;
    @(negedge clk);
    chunk_valid = 0; chunk_err = 0;
    for (int i = 0; i < 60 && !fin; i++) begin
      if (req_valid && !o_req) begin
        o_req = 1; o_kind = req_kind; o_addr = req_addr; o_len = req_len; o_off = req_offset;
        @(negedge clk); req_ready = 1;
        @(negedge clk); req_ready = 0;
        @(negedge clk); rsp_valid = 1; rsp_err = rerr;
        @(negedge clk); rsp_valid = 0; rsp_err = 0;
      end
      if (dma_end || chan_park) begin
        o_end = dma_end; o_park = chan_park; o_err = dma_err; o_ok = cmd_ok;
        o_irq = drv_irq; o_stat = drv_status; o_act = active; fin = 1;
      end else @(negedge clk);
    end
    chk(fin, "chunk outcome seen", fin, 1);
  endtask

  task automatic chk_xfer_end(input string tg);
    chk(o_end && !o_err && !o_park && !o_act, {tg, " R4 end pulse, inactive"},
        {o_end, o_err, o_park, o_act}, 4'b1000);
    if (m_opt) chk(o_ok && !o_irq && o_stat == 8'h00, {tg, " R4 optical done"},
                   {o_ok, o_irq, o_stat}, {2'b10, 8'h00});
    else chk(o_irq && !o_ok && o_stat == 8'h50, {tg, " R4 disk done"},
             {o_ok, o_irq, o_stat}, {2'b01, 8'h50});
    m_active = 0;
  endtask

  task automatic exp_chunk(input logic [31:0] a, input logic [15:0] l, input string tg);
    logic [63:0] eoff;
    drive_chunk(a, l, 0, 0);
    if (!m_active) begin
      chk(o_park && !o_end && !o_req, {tg, " R3 park"}, {o_park, o_end, o_req}, 3'b100);
    end else if (m_remain <= 0) begin
      chk(!o_req, {tg, " R4 no request"}, o_req, 0);
      chk_xfer_end(tg);
    end else if (l == 0) begin
      chk(o_end && !o_req && o_act && !o_ok && !o_irq && !o_err, {tg, " R5 burst end"},
          {o_end, o_req, o_act, o_ok, o_irq, o_err}, 6'b101000);
    end else begin
      eoff = ({32'd0, m_blk} * (m_opt ? 64'd2048 : 64'd512)) + m_idx;
      chk(o_req, {tg, " R7 request made"}, o_req, 1);
      chk(o_off == eoff, {tg, " R6 offset"}, o_off, eoff);
      chk(o_addr == a && o_len == l, {tg, " R7 addr/len"}, {o_addr, o_len}, {a, l});
      chk(o_kind == (m_opt ? 2'd0 : m_cmd), {tg, " R9 kind"}, o_kind, m_opt ? 2'd0 : m_cmd);
      m_remain -= int'(l);
      m_idx += l;
      if (m_remain <= 0) chk_xfer_end({tg, " R12"});
      else chk(o_end && o_act && !o_ok && !o_irq && !o_err, {tg, " R12 burst end"},
               {o_end, o_act, o_ok, o_irq, o_err}, 5'b11000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] bv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(active === 0 && chunk_ready === 1 && req_valid === 0 && dma_end === 0 &&
        chan_park === 0 && kick === 0 && dma_err === 0 && cmd_ok === 0 &&
        drv_irq === 0 && drv_status === 8'h00, "R1 reset state",
        {active, chunk_ready, req_valid, drv_status}, {3'b010, 8'h00});

    m_active = 0;
    exp_chunk(32'h40, 16'd512, "R3 before start");

    // hard disk sweep: commands, block addresses, sizes, chunk lengths
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 3; b++)
        for (int s = 1; s <= 3; s += 2) begin
          bv = (b == 0) ? 32'd0 : (b == 1) ? 32'd7 : 32'hFFFF_FFF0;
          do_start(0, 32'd0, 8'(s), bv, 2'(c));
          for (int k = 0; k < 8 && m_active; k++)
            exp_chunk(32'h1000_0000 + 32'(k) * 32'h100, (b == 1) ? 16'd700 : 16'd512, "hd sweep");
          exp_chunk(32'h80, 16'd512, "R3 after hd end");
        end

    // optical sweep, cmd set to write to show it is ignored
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 2; b++) begin
        do_start(1, (p == 0) ? 32'd2048 : (p == 1) ? 32'd3000 : 32'd1000, 8'd9,
                 (b == 0) ? 32'd3 : 32'h8000_0001, 2'd1);
        for (int k = 0; k < 8 && m_active; k++)
          exp_chunk(32'h2000_0000 + 32'(k) * 32'h800, 16'd2048, "optical sweep");
      end

    // zero-length chunk mid-transfer
    do_start(0, 32'd0, 8'd2, 32'd11, 2'd0);
    exp_chunk(32'h300, 16'd512, "R7 first");
    exp_chunk(32'h400, 16'd0, "R5 zero length");
    exp_chunk(32'h500, 16'd0, "R5 zero length again");
    exp_chunk(32'h600, 16'd512, "R7 after zero");

    // zero sector count: end at once
    do_start(0, 32'd0, 8'd0, 32'd5, 2'd2);
    exp_chunk(32'h700, 16'd512, "R4 zero count");

    // non-block copy, chunk larger than size
    do_start(1, 32'd100, 8'd0, 32'hFFFF_FFFF, 2'd0);
    drive_chunk(32'hA000, 16'd300, 0, 0);
    chk(o_req && o_kind == 2'd3 && o_len == 16'd100 && o_addr == 32'hA000,
        "R8 copy request small", {o_req, o_kind, o_len}, {1'b1, 2'd3, 16'd100});
    chk(o_ok && o_end && !o_act && !o_err, "R8 copy completes", {o_ok, o_end, o_act, o_err}, 4'b1100);
    // non-block copy, chunk smaller than size
    do_start(1, 32'd500, 8'd0, 32'hFFFF_FFFF, 2'd0);
    drive_chunk(32'hB000, 16'd200, 0, 0);
    chk(o_req && o_kind == 2'd3 && o_len == 16'd200, "R8 copy request chunk-limited",
        {o_req, o_kind, o_len}, {1'b1, 2'd3, 16'd200});
    chk(o_ok && o_end && !o_act, "R8 copy completes 2", {o_ok, o_end, o_act}, 3'b110);

    // illegal command on hard disk
    do_start(0, 32'd0, 8'd2, 32'd1, 2'd3);
    drive_chunk(32'hC000, 16'd512, 0, 0);
    chk(!o_req && o_err && o_end && !o_act, "R9 illegal cmd", {o_req, o_err, o_end, o_act}, 4'b0110);

    // error on chunk
    do_start(0, 32'd0, 8'd2, 32'd1, 2'd0);
    drive_chunk(32'hD000, 16'd512, 1, 0);
    chk(!o_req && o_err && o_end && !o_act, "R10 chunk error", {o_req, o_err, o_end, o_act}, 4'b0110);

    // error on response
    do_start(0, 32'd0, 8'd4, 32'd1, 2'd1);
    drive_chunk(32'hE000, 16'd512, 0, 1);
    chk(o_req && o_err && o_end && !o_act && !o_irq, "R10 response error",
        {o_req, o_err, o_end, o_act, o_irq}, 5'b11100);
    m_active = 0;
    exp_chunk(32'hF000, 16'd512, "R3 after error");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule